// File: doc/BRIEF.md
# Profile Select Generator with GPIO Masking

This block chooses which stored configuration profile is active. It produces a small vector of select bits, and each bit comes from its own cell. A cell takes its bit either from a software-held value, or from the GPIO inputs passed through a per-bit mask and OR-reduced. In both modes an optional inversion is applied to the result. With the default width of three select bits the block serves an eight-entry profile set. With two bits it serves a four-entry group. A profile can therefore be picked by pins, by software, or by a mix in which some bits come from pins and others from registers.

The select vector is registered once. It then indexes a bank of profile words, and the chosen word is presented whole on one output, which also serves as the readback of the active profile. A fast-lock output either follows a software value directly, or runs automatically. In automatic mode it is raised for a fixed number of cycles after every change of the registered select.

Top module: `profile_select_gen`

## Requirements
- R1: While reset is held and on the first sample after release, `sel_q` is 0, `active_word` is 0 and `fl_active` is 0 when `fl_use_reg` is 0.
- R2: When bit `GPIO_W+2` (use_reg) of a cell's configuration is 1, that select bit equals bit `GPIO_W+1` (reg_val) XOR bit `GPIO_W` (invert).
- R3: When use_reg is 0, the select bit equals the OR of (`gpio_in` AND mask) XOR invert, where mask is configuration bits `GPIO_W-1:0`, and GPIO bits outside the mask have no effect.
- R4: After reset every cell's mask, use_reg and invert are 0, so driving all GPIO inputs high leaves the select at 0.
- R5: Inversion is applied after the source choice, so the same GPIO level yields opposite bits with invert 0 and invert 1.
- R6: A GPIO change made between edges appears on `sel_q` after exactly one rising edge. A configuration write is captured on one edge and takes effect on `sel_q` at the next edge.
- R7: `active_word` always equals the whole stored word at index `sel_q`, and it changes on the same edge as `sel_q`.
- R8: A write with `prof_we` stores `prof_wdata` at `prof_waddr` on the edge. A write to an unselected index leaves `active_word` unchanged. A write to the selected index appears on `active_word` after that edge.
- R9: When `fl_use_reg` is 1, `fl_active` equals `fl_reg_val` whatever the select does.
- R10: When `fl_use_reg` is 0, every change of `sel_q` raises `fl_active` for exactly `FL_CYCLES` cycles from the edge that changed it, and it is then 0.
- R11: Each select bit has its own configuration, so register-sourced, GPIO-sourced and inverted bits combine in one select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_in | input | GPIO_W | GPIO input levels |
| cfg_we | input | 1 | Write strobe for one select-bit configuration |
| cfg_idx | input | IDX_W | Which select bit is configured |
| cfg_wdata | input | GPIO_W+3 | {use_reg, reg_val, invert, mask} |
| prof_we | input | 1 | Profile word write strobe |
| prof_waddr | input | SEL_W | Profile index written |
| prof_wdata | input | WORD_W | Profile word written |
| fl_use_reg | input | 1 | Fast-lock follows software value when 1 |
| fl_reg_val | input | 1 | Software fast-lock value |
| sel_q | output | SEL_W | Registered select vector |
| active_word | output | WORD_W | Word of the active profile (readback) |
| fl_active | output | 1 | Fast-lock control output |

## Verification
A corrupted cell configuration shows up as a wrong `sel_q` bit one edge after the GPIO or register pattern that exposes it, and `active_word` jumps to the wrong profile on that same edge. A damaged profile entry appears only while its index is selected, so every index is written with a distinct word and read back through selection. A fault in the fast-lock counter shows as `fl_active` ending one cycle early or late after a select change, so both the last high sample and the first low sample are checked.

// File: rtl/psg_pkg.sv
package psg_pkg;
   localparam int unsigned PSG_GPIO_W = 9;

   typedef struct packed {
      logic                  use_reg;
      logic                  reg_val;
      logic                  invert;
      logic [PSG_GPIO_W-1:0] mask;
   } sel_cfg_t;

   localparam int unsigned PSG_CFG_W = $bits(sel_cfg_t);
endpackage

// File: rtl/psg_sel_cell.sv
module psg_sel_cell
   import psg_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  sel_cfg_t              wr_cfg,
   input  logic [PSG_GPIO_W-1:0] gpio,
   output logic                  sel_bit
);
   sel_cfg_t cfg_q;
   logic     src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else if (wr_en) cfg_q <= wr_cfg;
   end

   always_comb begin
      src     = cfg_q.use_reg ? cfg_q.reg_val : |(gpio & cfg_q.mask);
      sel_bit = src ^ cfg_q.invert;
   end

   assert_mask_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (cfg_q.mask == '0 && !cfg_q.invert && !cfg_q.use_reg));
endmodule

// File: rtl/psg_profile_bank.sv
module psg_profile_bank #(
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [SEL_W-1:0]  rsel,
   output logic [WORD_W-1:0] rword
);
   localparam int unsigned NPROF = 1 << SEL_W;

   logic [WORD_W-1:0] mem [NPROF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NPROF; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rword = mem[rsel];

   assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/psg_fastlock.sv
module psg_fastlock #(
   parameter int unsigned FL_CYCLES = 4,
   parameter bit          AUTO_FL   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_change,
   input  logic use_reg,
   input  logic reg_val,
   output logic fl_out
);
   localparam int unsigned CNT_W = $clog2(FL_CYCLES + 1);

   generate
      if (AUTO_FL) begin : g_auto
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else if (sel_change) cnt <= CNT_W'(FL_CYCLES);
            else if (cnt != '0) cnt <= cnt - 1'b1;
         end

         assign fl_out = use_reg ? reg_val : (cnt != '0);

         assert_fl_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
            sel_change |=> (cnt == CNT_W'(FL_CYCLES)));
         assert_fl_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!sel_change && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
      end else begin : g_manual
         logic unused_chg;
         assign unused_chg = sel_change;
         assign fl_out     = use_reg & reg_val;
      end
   endgenerate
endmodule

// File: rtl/profile_select_gen.sv
module profile_select_gen
   import psg_pkg::*;
#(
   parameter int unsigned SEL_W     = 3,
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned FL_CYCLES = 4,
   parameter bit          AUTO_FL   = 1'b1,
   localparam int unsigned GPIO_W   = PSG_GPIO_W,
   localparam int unsigned IDX_W    = (SEL_W > 1) ? $clog2(SEL_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GPIO_W-1:0] gpio_in,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [GPIO_W+2:0] cfg_wdata,
   input  logic              prof_we,
   input  logic [SEL_W-1:0]  prof_waddr,
   input  logic [WORD_W-1:0] prof_wdata,
   input  logic              fl_use_reg,
   input  logic              fl_reg_val,
   output logic [SEL_W-1:0]  sel_q,
   output logic [WORD_W-1:0] active_word,
   output logic              fl_active
);
   generate
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("SEL_W must be 1 to 4");
      end
      if (WORD_W < 1) begin : g_bad_word
         $error("WORD_W must be at least 1");
      end
      if (FL_CYCLES < 1) begin : g_bad_fl
         $error("FL_CYCLES must be at least 1");
      end
   endgenerate

   logic [SEL_W-1:0] sel_d;
   sel_cfg_t         wr_cfg;

   assign wr_cfg = sel_cfg_t'(cfg_wdata);

   for (genvar b = 0; b < SEL_W; b++) begin : g_cell
      psg_sel_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (cfg_we && (cfg_idx == IDX_W'(b))),
         .wr_cfg  (wr_cfg),
         .gpio    (gpio_in),
         .sel_bit (sel_d[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else sel_q <= sel_d;
   end

   psg_profile_bank #(.SEL_W(SEL_W), .WORD_W(WORD_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (prof_we),
      .waddr (prof_waddr),
      .wdata (prof_wdata),
      .rsel  (sel_q),
      .rword (active_word)
   );

   psg_fastlock #(.FL_CYCLES(FL_CYCLES), .AUTO_FL(AUTO_FL)) u_fl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_change (sel_d != sel_q),
      .use_reg    (fl_use_reg),
      .reg_val    (fl_reg_val),
      .fl_out     (fl_active)
   );

   assert_word_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(sel_q) && !$past(prof_we)) |-> $stable(active_word));
endmodule

// File: tb/tb_profile_select_gen.sv
module tb_profile_select_gen;
   localparam int SEL_W = 3, WORD_W = 16, FL_CYCLES = 4, GPIO_W = 9, IDX_W = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [GPIO_W-1:0] gpio_in = '0;
   logic              cfg_we = 1'b0;
   logic [IDX_W-1:0]  cfg_idx = '0;
   logic [GPIO_W+2:0] cfg_wdata = '0;
   logic              prof_we = 1'b0;
   logic [SEL_W-1:0]  prof_waddr = '0;
   logic [WORD_W-1:0] prof_wdata = '0;
   logic              fl_use_reg = 1'b0;
   logic              fl_reg_val = 1'b0;
   logic [SEL_W-1:0]  sel_q;
   logic [WORD_W-1:0] active_word;
   logic              fl_active;

   int checks = 0, errors = 0;
   logic [WORD_W-1:0] model [8];

   always #2 clk = ~clk;

   profile_select_gen dut (.*);

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(int idx, bit ur, bit rv, bit inv, logic [GPIO_W-1:0] m);
      cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_wdata = {ur, rv, inv, m};
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic prof_write(int a, logic [WORD_W-1:0] d);
      prof_we = 1'b1; prof_waddr = SEL_W'(a); prof_wdata = d;
      tick();
      prof_we = 1'b0;
      model[a] = d;
   endtask

   task automatic t_reset();
      chk("R1 sel", 32'(sel_q), 0);
      chk("R1 word", 32'(active_word), 0);
      chk("R1 fl", 32'(fl_active), 0);
   endtask

   task automatic t_mask_reset();
      gpio_in = '1; tick(); tick();
      chk("R4 all-high gpio", 32'(sel_q), 0);
      gpio_in = '0;
   endtask

   task automatic t_load();
      for (int k = 0; k < 8; k++) prof_write(k, 16'hA000 + 16'(k * 16'h111));
      chk("R8 word at sel 0", 32'(active_word), 32'(model[0]));
   endtask

   task automatic t_reg_mode();
      cfg_write(0, 1, 1, 0, '0);
      chk("R6 cfg not yet active", 32'(sel_q), 0);
      tick();
      chk("R2 reg bit", 32'(sel_q), 1);
      chk("R7 word follows sel", 32'(active_word), 32'(model[1]));
      chk("R10 fl high after change", 32'(fl_active), 1);
      for (int i = 1; i < FL_CYCLES; i++) tick();
      chk("R10 fl last high cycle", 32'(fl_active), 1);
      tick();
      chk("R10 fl low after window", 32'(fl_active), 0);
   endtask

   task automatic t_gpio();
      cfg_write(1, 0, 0, 0, 9'h010);
      tick();
      gpio_in = 9'h1EF; tick();
      chk("R3 unmasked pins ignored", 32'(sel_q), 1);
      gpio_in = 9'h010; #1;
      chk("R6 no change before edge", 32'(sel_q), 1);
      tick();
      chk("R6 one edge latency", 32'(sel_q), 3);
      chk("R3 masked pin", 32'(active_word), 32'(model[3]));
   endtask

   task automatic t_invert_mix();
      cfg_write(2, 0, 0, 1, 9'h100);
      tick();
      chk("R5 invert with pin low", 32'(sel_q), 7);
      chk("R11 mixed sources", 32'(active_word), 32'(model[7]));
      gpio_in = 9'h110; tick();
      chk("R5 invert with pin high", 32'(sel_q), 3);
      cfg_write(0, 1, 0, 1, '0);
      tick();
      chk("R2 reg bit inverted", 32'(sel_q), 3);
      cfg_write(0, 1, 1, 1, '0);
      tick();
      chk("R11 reg bit 0 gpio bits", 32'(sel_q), 2);
      chk("R7 word exact", 32'(active_word), 32'(model[2]));
   endtask

   task automatic t_write_sel();
      prof_write(5, 16'h5A5A);
      chk("R8 unselected write no effect", 32'(active_word), 32'(model[2]));
      prof_write(2, 16'h1234);
      chk("R8 selected write visible", 32'(active_word), 32'h1234);
   endtask

   task automatic t_fl_internal();
      fl_use_reg = 1'b1; fl_reg_val = 1'b0;
      gpio_in = 9'h100; tick();
      chk("R9 internal low despite change", 32'(fl_active), 0);
      fl_reg_val = 1'b1; #1;
      chk("R9 internal high", 32'(fl_active), 1);
      fl_use_reg = 1'b0; fl_reg_val = 1'b0;
   endtask

   initial begin
      #1;
      t_reset();
      repeat (2) tick();
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_mask_reset();
      t_load();
      t_reg_mode();
      t_gpio();
      t_invert_mix();
      t_write_sel();
      t_fl_internal();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #20000;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule